// File: doc/BRIEF.md
# Arithmetic Status Flag and Branch Condition Unit

This block adds, subtracts, compares and increments 32-bit integers. For each operation it computes the six arithmetic status flags: carry, parity, auxiliary carry, zero, sign and overflow. It holds these flags in a 32-bit flags word, and each flag sits at its conventional bit position. A compare is a subtraction that keeps its flags and discards its difference. A branch stage uses this to decide whether a jump would be taken. It selects a condition, and the unit evaluates that condition against the stored flags.

Each operation is presented for one cycle with a valid strobe. The result, a write-enable for that result and the flags word are all registered, and they update at the clock edge that samples the strobe. The condition output is combinational from the stored flags. It therefore follows the condition select at once and reflects the most recent completed operation.

Top module: `flagcond_unit`

## Requirements
- R1: The flags word holds carry at bit 0, parity at bit 2, auxiliary carry at bit 4, zero at bit 6, sign at bit 7 and overflow at bit 11. Bit 1 always reads 1 and every other unlisted bit always reads 0. Reset loads 0x00000002 into the flags, 0 into the result and 0 into the write-enable.
- R2: Operation select 0 (add) produces a+b. Carry is the carry out of bit 31. Overflow is set when both operands share a sign and the result's sign differs from it.
- R3: Operation select 1 (sub) produces a-b. Carry is set when a < b as unsigned. Overflow is set when the operands differ in sign and the result's sign differs from a's sign.
- R4: Operation select 2 (compare) sets all six flags exactly as sub would. It leaves the write-enable low and the result output holds its previous value.
- R5: Operation select 3 (increment) produces a+1 and ignores b. It updates every status flag except carry, which keeps its stored value.
- R6: Zero is set exactly when all 32 result bits are 0, and sign equals result bit 31.
- R7: Parity is set when bits 7..0 of the result contain an even number of ones. Bits 31..8 have no effect on it.
- R8: Auxiliary carry is set when the operation carries into, or borrows into, bit 4, which is the carry out of the low nibble.
- R9: The condition select picks the condition, and the condition output is a combinational function of the stored flags. The encodings are:
  - 0: equal (ZF)
  - 1: not equal (!ZF)
  - 2: unsigned below (CF)
  - 3: signed less (SF^OF)
  - 4: signed greater-or-equal (!(SF^OF))
  - 5: signed less-or-equal (ZF | (SF^OF))
  - 6: signed greater (!ZF & !(SF^OF))
  - 7: unsigned above-or-equal (!CF)
- R10: When the valid strobe is low, the result and the flags keep their values and the write-enable is low, whatever the operands and operation select are.
- R11: Result, write-enable and flags take the new values at the clock edge that samples the valid strobe high. The write-enable is high for exactly one cycle after an add, sub or increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | Operation strobe |
| op_sel_i | input | 2 | Operation: 0 add, 1 sub, 2 compare, 3 increment |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand (ignored by increment) |
| cond_sel_i | input | 3 | Branch condition select |
| result_o | output | 32 | Registered result |
| wr_en_o | output | 1 | Result write enable, one cycle per writing operation |
| flags_o | output | 32 | Flags word |
| cond_met_o | output | 1 | Selected condition holds on stored flags |

## Verification
The hardest situations to reach are the ones where sign and overflow disagree. A signed condition gives the opposite answer to a naive sign test only there, and that happens only on signed wrap-around at 0x7FFFFFFF/0x80000000. The stimulus crosses a set of operand values clustered at those edges, at nibble and byte boundaries, and at all-ones and zero. It applies every operation to every pair in that set and evaluates all eight conditions after each one. Increment's carry preservation depends on history. It is checked against carries left behind both set and clear by the preceding operation in the sweep.

// File: rtl/flagcond_pkg.sv
package flagcond_pkg;

    localparam int FLAGS_W     = 32;
    localparam int FLAG_CF     = 0;
    localparam int FLAG_PF     = 2;
    localparam int FLAG_AF     = 4;
    localparam int FLAG_ZF     = 6;
    localparam int FLAG_SF     = 7;
    localparam int FLAG_OF     = 11;
    localparam logic [FLAGS_W-1:0] FLAGS_FIXED  = 32'h0000_0002;
    localparam logic [FLAGS_W-1:0] STATUS_MASK  = 32'h0000_08D5;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_CMP = 2'd2,
        OP_INC = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        CC_EQ = 3'd0,
        CC_NE = 3'd1,
        CC_B  = 3'd2,
        CC_L  = 3'd3,
        CC_GE = 3'd4,
        CC_LE = 3'd5,
        CC_G  = 3'd6,
        CC_AE = 3'd7
    } cond_e;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } status_t;

endpackage

// File: rtl/flagcond_alu.sv
module flagcond_alu
    import flagcond_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [1:0]       op_sel_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    output logic [WIDTH-1:0] res_o,
    output status_t          stat_o
);
    localparam int MSB = WIDTH - 1;

    logic             is_sub;
    logic [WIDTH-1:0] opnd_b;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   sum;

    always_comb begin
        is_sub = (op_sel_i == OP_SUB) || (op_sel_i == OP_CMP);
        opnd_b = (op_sel_i == OP_INC) ? WIDTH'(1) : opb_i;
        b_eff  = is_sub ? ~opnd_b : opnd_b;
        sum    = {1'b0, opa_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, is_sub};
        res_o  = sum[MSB:0];

        stat_o.cf = is_sub ? ~sum[WIDTH] : sum[WIDTH];
        stat_o.of = (opa_i[MSB] == b_eff[MSB]) && (sum[MSB] != opa_i[MSB]);
        stat_o.af = opa_i[4] ^ opnd_b[4] ^ sum[4];
        stat_o.pf = ~^sum[7:0];
        stat_o.zf = (sum[MSB:0] == '0);
        stat_o.sf = sum[MSB];
    end
endmodule

// File: rtl/flagcond_cond.sv
module flagcond_cond
    import flagcond_pkg::*;
(
    input  logic [FLAGS_W-1:0] flags_i,
    input  logic [2:0]         cond_sel_i,
    output logic               met_o
);
    logic lt;

    always_comb begin
        lt = flags_i[FLAG_SF] ^ flags_i[FLAG_OF];
        unique case (cond_sel_i)
            CC_EQ:   met_o =  flags_i[FLAG_ZF];
            CC_NE:   met_o = ~flags_i[FLAG_ZF];
            CC_B:    met_o =  flags_i[FLAG_CF];
            CC_L:    met_o =  lt;
            CC_GE:   met_o = ~lt;
            CC_LE:   met_o =  flags_i[FLAG_ZF] | lt;
            CC_G:    met_o = ~flags_i[FLAG_ZF] & ~lt;
            default: met_o = ~flags_i[FLAG_CF];
        endcase
    end
endmodule

// File: rtl/flagcond_unit.sv
module flagcond_unit
    import flagcond_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid_i,
    input  logic [1:0]         op_sel_i,
    input  logic [WIDTH-1:0]   opa_i,
    input  logic [WIDTH-1:0]   opb_i,
    input  logic [2:0]         cond_sel_i,
    output logic [WIDTH-1:0]   result_o,
    output logic               wr_en_o,
    output logic [FLAGS_W-1:0] flags_o,
    output logic               cond_met_o
);
    typedef struct packed {
        logic [WIDTH-1:0]   result;
        logic               wr_en;
        logic [FLAGS_W-1:0] flags;
    } state_t;

    state_t           state_d, state_q;
    logic [WIDTH-1:0] alu_res;
    status_t          alu_stat;

    flagcond_alu #(.WIDTH(WIDTH)) u_alu (
        .op_sel_i (op_sel_i),
        .opa_i    (opa_i),
        .opb_i    (opb_i),
        .res_o    (alu_res),
        .stat_o   (alu_stat)
    );

    always_comb begin
        state_d       = state_q;
        state_d.wr_en = 1'b0;
        if (op_valid_i) begin
            state_d.flags          = FLAGS_FIXED;
            state_d.flags[FLAG_CF] = (op_sel_i == OP_INC) ? state_q.flags[FLAG_CF]
                                                          : alu_stat.cf;
            state_d.flags[FLAG_PF] = alu_stat.pf;
            state_d.flags[FLAG_AF] = alu_stat.af;
            state_d.flags[FLAG_ZF] = alu_stat.zf;
            state_d.flags[FLAG_SF] = alu_stat.sf;
            state_d.flags[FLAG_OF] = alu_stat.of;
            if (op_sel_i != OP_CMP) begin
                state_d.result = alu_res;
                state_d.wr_en  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.result <= '0;
            state_q.wr_en  <= 1'b0;
            state_q.flags  <= FLAGS_FIXED;
        end else begin
            state_q <= state_d;
        end
    end

    flagcond_cond u_cond (
        .flags_i    (state_q.flags),
        .cond_sel_i (cond_sel_i),
        .met_o      (cond_met_o)
    );

    assign result_o = state_q.result;
    assign wr_en_o  = state_q.wr_en;
    assign flags_o  = state_q.flags;
endmodule

// File: rtl/flagcond_chk.sv
module flagcond_chk
    import flagcond_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               op_valid_i,
    input logic [1:0]         op_sel_i,
    input logic [WIDTH-1:0]   result_o,
    input logic               wr_en_o,
    input logic [FLAGS_W-1:0] flags_o
);
    assert_fixed_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o & ~STATUS_MASK) == FLAGS_FIXED);

    assert_cmp_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_sel_i == OP_CMP) |=> (!wr_en_o && $stable(result_o)));

    assert_inc_keeps_cf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_sel_i == OP_INC) |=> $stable(flags_o[FLAG_CF]));

    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (flags_o[FLAG_ZF] == (result_o == '0)));

    assert_sign_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (flags_o[FLAG_SF] == result_o[WIDTH-1]));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> ($stable(flags_o) && $stable(result_o) && !wr_en_o));

    assert_write_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_sel_i != OP_CMP) |=> wr_en_o);
endmodule

bind flagcond_unit flagcond_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid_i (op_valid_i),
    .op_sel_i   (op_sel_i),
    .result_o   (result_o),
    .wr_en_o    (wr_en_o),
    .flags_o    (flags_o)
);

// File: tb/flagcond_unit_bench.sv
`timescale 1ns/1ps
module flagcond_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_sel = 2'd0;
    logic [31:0] opa = '0, opb = '0;
    logic [2:0]  cond_sel = 3'd0;
    logic [31:0] result;
    logic        wr_en;
    logic [31:0] flags;
    logic        cond_met;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] exp_res   = '0;
    logic [31:0] exp_flags = 32'h2;

    always #10 clk = ~clk;

    flagcond_unit u_flagcond_unit (
        .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid), .op_sel_i(op_sel),
        .opa_i(opa), .opb_i(opb), .cond_sel_i(cond_sel),
        .result_o(result), .wr_en_o(wr_en), .flags_o(flags), .cond_met_o(cond_met)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pack(input logic cf, pf, af, zf, sf, of_);
        logic [31:0] f;
        f = 32'h2;
        f[0] = cf; f[2] = pf; f[4] = af; f[6] = zf; f[7] = sf; f[11] = of_;
        return f;
    endfunction

    // Reference model: R2, R3, R5, R6, R7, R8 computed arithmetically
    task automatic model(input int op, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r;
        logic        cf, af, of_, pf;
        longint      sa, sb, sr;
        int          ones;
        logic [32:0] wide;
        sa = longint'($signed(a));
        if (op == 3) b = 32'd1;
        sb = longint'($signed(b));
        if (op == 1 || op == 2) begin
            r   = a - b;
            cf  = (a < b);
            af  = (a[3:0] < b[3:0]);
            sr  = sa - sb;
        end else begin
            wide = {1'b0, a} + {1'b0, b};
            r    = wide[31:0];
            cf   = (op == 3) ? exp_flags[0] : wide[32];
            af   = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
            sr   = sa + sb;
        end
        of_  = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(r[i]);
        pf = (ones % 2 == 0);
        exp_flags = pack(cf, pf, af, (r == 0), r[31], of_);
        if (op != 2) exp_res = r;
    endtask

    function automatic logic exp_cond(input int c, input logic [31:0] f);
        logic lt;
        lt = f[7] ^ f[11];
        case (c)
            0: return f[6];
            1: return !f[6];
            2: return f[0];
            3: return lt;
            4: return !lt;
            5: return f[6] || lt;
            6: return !f[6] && !lt;
            default: return !f[0];
        endcase
    endfunction

    task automatic do_op(input int op, input logic [31:0] a, input logic [31:0] b, input string req);
        @(negedge clk);
        op_valid = 1'b1; op_sel = op[1:0]; opa = a; opb = b;
        model(op, a, b);
        @(negedge clk);
        op_valid = 1'b0;
        chk({req, " result (R11)"}, result, exp_res);
        chk({req, " wr_en (R4/R11)"}, {31'd0, wr_en}, {31'd0, op != 2});
        chk({req, " flags (R1/R6/R7/R8)"}, flags, exp_flags);
        for (int c = 0; c < 8; c++) begin
            cond_sel = c[2:0];
            #1;
            chk({req, " cond R9"}, {31'd0, cond_met}, {31'd0, exp_cond(c, exp_flags)});
        end
    endtask

    logic [31:0] vals [16] = '{
        32'h0000_0000, 32'h0000_0001, 32'h0000_0002, 32'h0000_000F,
        32'h0000_0010, 32'h0000_007F, 32'h0000_0080, 32'h0000_00FF,
        32'h7FFF_FFFF, 32'h8000_0000, 32'h8000_0001, 32'hFFFF_FFFF,
        32'hFFFF_FFFE, 32'h1234_5678, 32'h0000_FFFF, 32'hAAAA_AAAA
    };

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset flags", flags, 32'h0000_0002);
        chk("R1 reset result", result, 32'h0);
        chk("R1 reset wr_en", {31'd0, wr_en}, 32'd0);
        rst_n = 1'b1;

        // Named boundary cases
        do_op(0, 32'h7FFF_FFFF, 32'h1, "R2 max+1");
        do_op(1, 32'h8000_0000, 32'h1, "R3 min-1");
        do_op(1, 32'h0, 32'h1, "R3 0-1");
        do_op(2, 32'h1234_5678, 32'h1234_5678, "R4 equal");
        do_op(3, 32'hFFFF_FFFF, 32'h5555_5555, "R5 inc wrap");
        do_op(0, 32'h0000_FF00, 32'h0000_0000, "R7 upper bits");

        // R10: idle cycle with changing inputs
        @(negedge clk);
        op_sel = 2'd0; opa = 32'hDEAD_BEEF; opb = 32'h1;
        @(negedge clk);
        chk("R10 idle result", result, exp_res);
        chk("R10 idle flags", flags, exp_flags);
        chk("R10 idle wr_en", {31'd0, wr_en}, 32'd0);

        // Near-exhaustive sweep over the value set
        for (int op = 0; op < 4; op++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++)
                    do_op(op, vals[i], vals[j], "sweep R2/R3/R4/R5");

        // Increment after carry set and after carry clear (R5)
        do_op(1, 32'h0, 32'h5, "R3 borrow set");
        do_op(3, 32'h0000_000F, 32'h0, "R5 inc keeps cf=1");
        do_op(0, 32'h1, 32'h1, "R2 carry clear");
        do_op(3, 32'h7FFF_FFFF, 32'h0, "R5 inc keeps cf=0");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule